// File: doc/BRIEF.md
# Scalar Integer Execute and Branch Unit

This block is the execute stage of a single-issue 32-bit scalar integer core with a classic three-format instruction word. Each cycle it may accept one instruction word together with the program counter and the two source operand values already read from the register file. It decodes the instruction and returns, one clock later, a register-file write request, the address of the next instruction, and any change to the core's halt status. The arithmetic covers shifts, wrapping add and subtract, bitwise logic, signed and unsigned compares, immediate forms and load-upper. The control-flow part covers conditional branches, absolute jumps, register jumps and their linking forms.

Two behaviours need attention. The branch-and-link-if-non-negative form always writes its return address, taken or not. The break instruction stops the core by setting sticky halt and broke flags, and it raises a one-cycle interrupt request when the break-interrupt enable input is high. Any encoding outside the supported subset is reported with a one-cycle illegal-instruction flag and changes no state. Memory access, coprocessor operations and hazard handling live elsewhere in the core.

Top module: `ex_scalar_unit`

## Requirements
- R1: Bits 31:26 select the primary operation; primary value 0 takes its sub-operation from bits 5:0 and primary value 1 from bits 20:16. Every output is registered: an instruction accepted with `issue_valid` high produces `res_valid` high one clock later, and a cycle without `issue_valid` produces `res_valid`, `wr_en`, `illegal` and `irq` low.
- R2: Shift functions 0x00, 0x02 and 0x03 shift rt by bits 10:6; 0x04, 0x06 and 0x07 shift rt by the low 5 bits of rs. 0x03 and 0x07 are arithmetic right shifts, 0x02 and 0x06 logical right shifts, 0x00 and 0x04 left shifts. The destination of every primary-0 operation is bits 15:11.
- R3: Functions 0x20/0x21 add and 0x22/0x23 subtract rs and rt modulo 2^32 with no exception; 0x24..0x27 give AND, OR, XOR, NOR; 0x2A is a signed and 0x2B an unsigned less-than producing 1 or 0.
- R4: Immediate operations write to bits 20:16: 0x08/0x09 add the sign-extended immediate, 0x0A compares signed against it, 0x0B sign-extends it and compares unsigned, 0x0C/0x0D/0x0E apply AND/OR/XOR with the zero-extended immediate, and 0x0F places the immediate in bits 31:16 with zeros below.
- R5: No instruction ever writes register 0: `wr_en` stays low whenever the destination index is 0.
- R6: Primary 0x04/0x05/0x06/0x07 branch on rs==rt, rs!=rt, rs<=0, rs>0 (signed); sub-operations 0x00/0x01 of primary 1 branch on rs<0 and rs>=0. A taken branch gives `next_pc` = pc+4 + (sign-extended immediate << 2); every other non-jump instruction gives pc+4.
- R7: Sub-operation 0x11 of primary 1 branches like rs>=0 and always writes pc+8 to register 31, whether or not the branch is taken.
- R8: Primary 0x02 and 0x03 jump to {bits 31:28 of pc+4, bits 25:0, 00}; 0x03 writes pc+8 to register 31. Function 0x08 jumps to rs; function 0x09 jumps to rs and writes pc+8 to the register in bits 15:11.
- R9: Function 0x0D sets the `halted` and `broke` flags, which stay set until reset; it raises `irq` for exactly one cycle when `break_irq_en` was high at issue.
- R10: Any other encoding raises `illegal` for one cycle, leaves `wr_en` low, leaves `halted`, `broke` and `irq` unchanged and low respectively, and gives `next_pc` = pc+4.
- R11: Reset, synchronous and active high, clears every output and both status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| break_irq_en | input | 1 | Break raises an interrupt request when high |
| res_valid | output | 1 | Results below belong to an accepted instruction |
| wr_en | output | 1 | Register-file write enable |
| wr_idx | output | 5 | Register-file write index |
| wr_data | output | 32 | Register-file write data |
| next_pc | output | 32 | Address of the next instruction |
| illegal | output | 1 | One-cycle illegal-instruction flag |
| halted | output | 1 | Sticky halt flag |
| broke | output | 1 | Sticky break flag |
| irq | output | 1 | One-cycle interrupt request from break |

## Verification
On every cycle the checker confirms that register 0 is never written, that idle cycles and illegal encodings produce no write, that the halt and broke flags move together and never clear outside reset, that an interrupt request only follows a break issued with the enable high, and that the linking non-negative branch always writes register 31. The values themselves (shift results, wrap-around sums, the sign-versus-zero extension of immediates, branch and jump targets, and the taken and not-taken paths) only appear in the bench's scenarios, which compare each result against a reference model built from the requirements.

// File: rtl/ex_pkg.sv
package ex_pkg;

    localparam int XLEN    = 32;
    localparam int REG_W   = 5;
    localparam int IMM_W   = 16;
    localparam int INDEX_W = 26;
    localparam int SHAMT_W = $clog2(XLEN);

    // primary operation values
    localparam logic [5:0] OP_SPECIAL = 6'h00;
    localparam logic [5:0] OP_REGIMM  = 6'h01;
    localparam logic [5:0] OP_J       = 6'h02;
    localparam logic [5:0] OP_JAL     = 6'h03;
    localparam logic [5:0] OP_BEQ     = 6'h04;
    localparam logic [5:0] OP_BNE     = 6'h05;
    localparam logic [5:0] OP_BLEZ    = 6'h06;
    localparam logic [5:0] OP_BGTZ    = 6'h07;
    localparam logic [5:0] OP_ADDI    = 6'h08;
    localparam logic [5:0] OP_ADDIU   = 6'h09;
    localparam logic [5:0] OP_SLTI    = 6'h0A;
    localparam logic [5:0] OP_SLTIU   = 6'h0B;
    localparam logic [5:0] OP_ANDI    = 6'h0C;
    localparam logic [5:0] OP_ORI     = 6'h0D;
    localparam logic [5:0] OP_XORI    = 6'h0E;
    localparam logic [5:0] OP_LUI     = 6'h0F;

    // primary-1 sub-operations
    localparam logic [4:0] RI_LTZ    = 5'h00;
    localparam logic [4:0] RI_GEZ    = 5'h01;
    localparam logic [4:0] RI_GEZ_LK = 5'h11;

    localparam logic [REG_W-1:0] LINK_REG = 5'd31;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
        ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_SRA,
        ALU_PASSB, ALU_LINK
    } alu_op_e;

    typedef enum logic [1:0] {
        OPB_RT, OPB_SIMM, OPB_ZIMM, OPB_UPPER
    } opb_sel_e;

    typedef enum logic [3:0] {
        BR_NONE, BR_EQ, BR_NE, BR_LEZ, BR_GTZ, BR_LTZ, BR_GEZ,
        BR_ABS, BR_REG
    } br_kind_e;

    typedef struct packed {
        alu_op_e          alu_op;
        opb_sel_e         opb;
        logic             var_shift;
        br_kind_e         br;
        logic             wr_req;
        logic [REG_W-1:0] dest;
        logic             is_break;
        logic             illegal;
    } dec_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] zext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/ex_decode.sv
module ex_decode
    import ex_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output dec_t            dec
);
    logic [5:0]       opc;
    logic [5:0]       fn;
    logic [REG_W-1:0] rt_f;
    logic [REG_W-1:0] rd_f;
    logic [REG_W-1:0] unused_rs_f;

    assign opc         = instr[31:26];
    assign fn          = instr[5:0];
    assign rt_f        = instr[20:16];
    assign rd_f        = instr[15:11];
    assign unused_rs_f = instr[25:21];

    always_comb begin
        dec        = '0;
        dec.alu_op = ALU_ADD;
        dec.opb    = OPB_RT;
        dec.br     = BR_NONE;
        unique case (opc)
            OP_SPECIAL: begin
                dec.dest   = rd_f;
                dec.wr_req = 1'b1;
                case (fn)
                    6'h00: dec.alu_op = ALU_SLL;
                    6'h02: dec.alu_op = ALU_SRL;
                    6'h03: dec.alu_op = ALU_SRA;
                    6'h04: begin dec.alu_op = ALU_SLL; dec.var_shift = 1'b1; end
                    6'h06: begin dec.alu_op = ALU_SRL; dec.var_shift = 1'b1; end
                    6'h07: begin dec.alu_op = ALU_SRA; dec.var_shift = 1'b1; end
                    6'h08: begin dec.br = BR_REG; dec.wr_req = 1'b0; end
                    6'h09: begin dec.br = BR_REG; dec.alu_op = ALU_LINK; end
                    6'h0D: begin dec.is_break = 1'b1; dec.wr_req = 1'b0; end
                    6'h20, 6'h21: dec.alu_op = ALU_ADD;
                    6'h22, 6'h23: dec.alu_op = ALU_SUB;
                    6'h24: dec.alu_op = ALU_AND;
                    6'h25: dec.alu_op = ALU_OR;
                    6'h26: dec.alu_op = ALU_XOR;
                    6'h27: dec.alu_op = ALU_NOR;
                    6'h2A: dec.alu_op = ALU_SLT;
                    6'h2B: dec.alu_op = ALU_SLTU;
                    default: begin dec.illegal = 1'b1; dec.wr_req = 1'b0; end
                endcase
            end
            OP_REGIMM: begin
                case (rt_f)
                    RI_LTZ: dec.br = BR_LTZ;
                    RI_GEZ: dec.br = BR_GEZ;
                    RI_GEZ_LK: begin
                        dec.br     = BR_GEZ;
                        dec.alu_op = ALU_LINK;
                        dec.wr_req = 1'b1;
                        dec.dest   = LINK_REG;
                    end
                    default: dec.illegal = 1'b1;
                endcase
            end
            OP_J:    dec.br = BR_ABS;
            OP_JAL: begin
                dec.br     = BR_ABS;
                dec.alu_op = ALU_LINK;
                dec.wr_req = 1'b1;
                dec.dest   = LINK_REG;
            end
            OP_BEQ:  dec.br = BR_EQ;
            OP_BNE:  dec.br = BR_NE;
            OP_BLEZ: dec.br = BR_LEZ;
            OP_BGTZ: dec.br = BR_GTZ;
            OP_ADDI, OP_ADDIU, OP_SLTI, OP_SLTIU,
            OP_ANDI, OP_ORI, OP_XORI, OP_LUI: begin
                dec.dest   = rt_f;
                dec.wr_req = 1'b1;
                case (opc)
                    OP_SLTI:  begin dec.alu_op = ALU_SLT;   dec.opb = OPB_SIMM;  end
                    OP_SLTIU: begin dec.alu_op = ALU_SLTU;  dec.opb = OPB_SIMM;  end
                    OP_ANDI:  begin dec.alu_op = ALU_AND;   dec.opb = OPB_ZIMM;  end
                    OP_ORI:   begin dec.alu_op = ALU_OR;    dec.opb = OPB_ZIMM;  end
                    OP_XORI:  begin dec.alu_op = ALU_XOR;   dec.opb = OPB_ZIMM;  end
                    OP_LUI:   begin dec.alu_op = ALU_PASSB; dec.opb = OPB_UPPER; end
                    default:  begin dec.alu_op = ALU_ADD;   dec.opb = OPB_SIMM;  end
                endcase
            end
            default: dec.illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/ex_alu.sv
module ex_alu
    import ex_pkg::*;
(
    input  alu_op_e            op,
    input  logic [XLEN-1:0]    a,
    input  logic [XLEN-1:0]    b,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic [XLEN-1:0]    link_addr,
    output logic [XLEN-1:0]    y
);
    logic [XLEN-1:0] sum;
    logic [XLEN-1:0] diff;
    logic            lt_s;
    logic            lt_u;

    assign sum  = a + b;
    assign diff = a - b;
    assign lt_s = $signed(a) < $signed(b);
    assign lt_u = a < b;

    always_comb begin
        unique case (op)
            ALU_ADD:   y = sum;
            ALU_SUB:   y = diff;
            ALU_AND:   y = a & b;
            ALU_OR:    y = a | b;
            ALU_XOR:   y = a ^ b;
            ALU_NOR:   y = ~(a | b);
            ALU_SLT:   y = {{(XLEN-1){1'b0}}, lt_s};
            ALU_SLTU:  y = {{(XLEN-1){1'b0}}, lt_u};
            ALU_SLL:   y = b << shamt;
            ALU_SRL:   y = b >> shamt;
            ALU_SRA:   y = $unsigned($signed(b) >>> shamt);
            ALU_PASSB: y = b;
            ALU_LINK:  y = link_addr;
            default:   y = '0;
        endcase
    end
endmodule

// File: rtl/ex_branch.sv
module ex_branch
    import ex_pkg::*;
(
    input  br_kind_e           kind,
    input  logic [XLEN-1:0]    pc,
    input  logic [XLEN-1:0]    rs,
    input  logic [XLEN-1:0]    rt,
    input  logic [INDEX_W-1:0] index,
    output logic [XLEN-1:0]    next_pc,
    output logic [XLEN-1:0]    link_addr
);
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] rel_target;
    logic [XLEN-1:0] abs_target;
    logic            rs_neg;
    logic            rs_zero;
    logic            take;

    assign seq_pc     = pc + XLEN'(4);
    assign link_addr  = pc + XLEN'(8);
    assign rel_target = seq_pc + {sext_imm(index[IMM_W-1:0])[XLEN-3:0], 2'b00};
    assign abs_target = {seq_pc[XLEN-1:INDEX_W+2], index, 2'b00};
    assign rs_neg     = rs[XLEN-1];
    assign rs_zero    = (rs == '0);

    always_comb begin
        unique case (kind)
            BR_EQ:   take = (rs == rt);
            BR_NE:   take = (rs != rt);
            BR_LEZ:  take = rs_neg | rs_zero;
            BR_GTZ:  take = ~rs_neg & ~rs_zero;
            BR_LTZ:  take = rs_neg;
            BR_GEZ:  take = ~rs_neg;
            default: take = 1'b0;
        endcase
    end

    always_comb begin
        unique case (kind)
            BR_ABS:  next_pc = abs_target;
            BR_REG:  next_pc = rs;
            default: next_pc = take ? rel_target : seq_pc;
        endcase
    end
endmodule

// File: rtl/ex_scalar_unit.sv
module ex_scalar_unit
    import ex_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_valid,
    input  logic [XLEN-1:0]  instr,
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  rs_val,
    input  logic [XLEN-1:0]  rt_val,
    input  logic             break_irq_en,
    output logic             res_valid,
    output logic             wr_en,
    output logic [REG_W-1:0] wr_idx,
    output logic [XLEN-1:0]  wr_data,
    output logic [XLEN-1:0]  next_pc,
    output logic             illegal,
    output logic             halted,
    output logic             broke,
    output logic             irq
);
    dec_t               dec;
    br_kind_e           br_kind;
    logic [XLEN-1:0]    opb;
    logic [SHAMT_W-1:0] shamt;
    logic [XLEN-1:0]    alu_y;
    logic [XLEN-1:0]    br_next;
    logic [XLEN-1:0]    link_addr;
    logic               do_write;
    logic               do_break;

    ex_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    always_comb begin
        unique case (dec.opb)
            OPB_SIMM:  opb = sext_imm(instr[IMM_W-1:0]);
            OPB_ZIMM:  opb = zext_imm(instr[IMM_W-1:0]);
            OPB_UPPER: opb = {instr[IMM_W-1:0], {(XLEN-IMM_W){1'b0}}};
            default:   opb = rt_val;
        endcase
    end

    assign shamt   = dec.var_shift ? rs_val[SHAMT_W-1:0] : instr[10:6];
    assign br_kind = dec.illegal ? BR_NONE : dec.br;

    ex_branch u_br (
        .kind      (br_kind),
        .pc        (pc),
        .rs        (rs_val),
        .rt        (rt_val),
        .index     (instr[INDEX_W-1:0]),
        .next_pc   (br_next),
        .link_addr (link_addr)
    );

    ex_alu u_alu (
        .op        (dec.alu_op),
        .a         (rs_val),
        .b         (opb),
        .shamt     (shamt),
        .link_addr (link_addr),
        .y         (alu_y)
    );

    assign do_write = issue_valid && !dec.illegal && dec.wr_req && (dec.dest != '0);
    assign do_break = issue_valid && !dec.illegal && dec.is_break;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
            next_pc   <= '0;
            illegal   <= 1'b0;
            halted    <= 1'b0;
            broke     <= 1'b0;
            irq       <= 1'b0;
        end else begin
            res_valid <= issue_valid;
            wr_en     <= do_write;
            illegal   <= issue_valid && dec.illegal;
            irq       <= do_break && break_irq_en;
            if (issue_valid) begin
                wr_idx  <= dec.dest;
                wr_data <= alu_y;
                next_pc <= br_next;
            end
            if (do_break) begin
                halted <= 1'b1;
                broke  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ex_scalar_unit_chk.sv
module ex_scalar_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       issue_valid,
    input logic [5:0] opc,
    input logic [4:0] sub_rt,
    input logic       break_irq_en,
    input logic       res_valid,
    input logic       wr_en,
    input logic [4:0] wr_idx,
    input logic       illegal,
    input logic       halted,
    input logic       broke,
    input logic       irq
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (!wr_en && !illegal && !irq));

    assert_no_r0_write_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_idx != 5'd0));

    assert_link_always_R7: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && opc == 6'h01 && sub_rt == 5'h11) |=> (wr_en && wr_idx == 5'd31));

    assert_sticky_halt_R9: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    assert_halt_broke_pair_R9: assert property (@(posedge clk) disable iff (rst)
        halted == broke);

    assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(break_irq_en) && halted));

    assert_illegal_no_write_R10: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!wr_en && !irq && res_valid));
endmodule

bind ex_scalar_unit ex_scalar_unit_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .issue_valid  (issue_valid),
    .opc          (instr[31:26]),
    .sub_rt       (instr[20:16]),
    .break_irq_en (break_irq_en),
    .res_valid    (res_valid),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .illegal      (illegal),
    .halted       (halted),
    .broke        (broke),
    .irq          (irq)
);

// File: tb/ex_scalar_unit_test.sv
`timescale 1ns/1ps
module ex_scalar_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] pc = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic        break_irq_en = 1'b0;
    logic        res_valid, wr_en, illegal, halted, broke, irq;
    logic [4:0]  wr_idx;
    logic [31:0] wr_data, next_pc;

    always #2.5 clk = ~clk;

    ex_scalar_unit uut (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .instr(instr),
        .pc(pc), .rs_val(rs_val), .rt_val(rt_val), .break_irq_en(break_irq_en),
        .res_valid(res_valid), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .next_pc(next_pc), .illegal(illegal), .halted(halted), .broke(broke),
        .irq(irq)
    );

    typedef struct packed {
        logic        we;
        logic [4:0]  idx;
        logic [31:0] data;
        logic [31:0] npc;
        logic        ill;
        logic        hlt;
        logic        brk;
        logic        irq;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_checks = 0;
    int    n_fail = 0;
    bit    model_halted = 1'b0;
    bit    finished = 1'b0;

    function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, sa, input logic [5:0] fn);
        return {6'h00, rs, rt, rd, sa, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic exp_t model(input logic [31:0] ins, p, rs, rt, input bit en, input bit h_in);
        exp_t e;
        logic [31:0] se, ze, seq, lnk, rel;
        logic [4:0]  sa;
        bit take, brk;
        e = '0;
        se  = {{16{ins[15]}}, ins[15:0]};
        ze  = {16'h0, ins[15:0]};
        seq = p + 32'd4;
        lnk = p + 32'd8;
        rel = seq + (se << 2);
        sa  = ins[10:6];
        take = 0;
        brk  = 0;
        e.npc = seq;
        case (ins[31:26])
            6'h00: begin
                e.idx = ins[15:11];
                e.we  = 1;
                case (ins[5:0])
                    6'h00: e.data = rt << sa;
                    6'h02: e.data = rt >> sa;
                    6'h03: e.data = $unsigned($signed(rt) >>> sa);
                    6'h04: e.data = rt << rs[4:0];
                    6'h06: e.data = rt >> rs[4:0];
                    6'h07: e.data = $unsigned($signed(rt) >>> rs[4:0]);
                    6'h08: begin e.we = 0; e.npc = rs; end
                    6'h09: begin e.data = lnk; e.npc = rs; end
                    6'h0D: begin e.we = 0; brk = 1; end
                    6'h20, 6'h21: e.data = rs + rt;
                    6'h22, 6'h23: e.data = rs - rt;
                    6'h24: e.data = rs & rt;
                    6'h25: e.data = rs | rt;
                    6'h26: e.data = rs ^ rt;
                    6'h27: e.data = ~(rs | rt);
                    6'h2A: e.data = {31'h0, $signed(rs) < $signed(rt)};
                    6'h2B: e.data = {31'h0, rs < rt};
                    default: begin e.we = 0; e.ill = 1; end
                endcase
            end
            6'h01: begin
                case (ins[20:16])
                    5'h00: take = $signed(rs) < 0;
                    5'h01: take = $signed(rs) >= 0;
                    5'h11: begin take = $signed(rs) >= 0; e.we = 1; e.idx = 31; e.data = lnk; end
                    default: e.ill = 1;
                endcase
                if (take) e.npc = rel;
            end
            6'h02: e.npc = {seq[31:28], ins[25:0], 2'b00};
            6'h03: begin e.npc = {seq[31:28], ins[25:0], 2'b00}; e.we = 1; e.idx = 31; e.data = lnk; end
            6'h04: if (rs == rt) e.npc = rel;
            6'h05: if (rs != rt) e.npc = rel;
            6'h06: if ($signed(rs) <= 0) e.npc = rel;
            6'h07: if ($signed(rs) > 0) e.npc = rel;
            6'h08, 6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h0D, 6'h0E, 6'h0F: begin
                e.we  = 1;
                e.idx = ins[20:16];
                case (ins[31:26])
                    6'h0A: e.data = {31'h0, $signed(rs) < $signed(se)};
                    6'h0B: e.data = {31'h0, rs < se};
                    6'h0C: e.data = rs & ze;
                    6'h0D: e.data = rs | ze;
                    6'h0E: e.data = rs ^ ze;
                    6'h0F: e.data = {ins[15:0], 16'h0};
                    default: e.data = rs + se;
                endcase
            end
            default: e.ill = 1;
        endcase
        if (e.idx == 5'd0) e.we = 0;
        e.hlt = h_in | brk;
        e.brk = e.hlt;
        e.irq = brk & en;
        return e;
    endfunction

    task automatic issue(input logic [31:0] ins, p, rs, rt, input bit en, input string tag);
        exp_t e;
        @(negedge clk);
        instr        = ins;
        pc           = p;
        rs_val       = rs;
        rt_val       = rt;
        break_irq_en = en;
        issue_valid  = 1'b1;
        e = model(ins, p, rs, rt, en, model_halted);
        model_halted = e.hlt;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor: compares each produced result with the oldest expectation
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            exp_t  e;
            string t;
            bit    bad;
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R1 unexpected result: res_valid=1 expected=0");
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                bad = (wr_en !== e.we) || (e.we && (wr_idx !== e.idx || wr_data !== e.data)) ||
                      (next_pc !== e.npc) || (illegal !== e.ill) || (halted !== e.hlt) ||
                      (broke !== e.brk) || (irq !== e.irq);
                if (bad) begin
                    n_fail++;
                    $display("FAIL %s: actual we=%0b idx=%0d data=%h npc=%h ill=%0b h=%0b b=%0b irq=%0b expected we=%0b idx=%0d data=%h npc=%h ill=%0b h=%0b b=%0b irq=%0b",
                             t, wr_en, wr_idx, wr_data, next_pc, illegal, halted, broke, irq,
                             e.we, e.idx, e.data, e.npc, e.ill, e.hlt, e.brk, e.irq);
                end
            end
        end
    end

    task automatic check_bit(input string tag, input logic act, input logic expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check_bit("R11 res_valid", res_valid, 1'b0);
        check_bit("R11 wr_en", wr_en, 1'b0);
        check_bit("R11 halted", halted, 1'b0);
        check_bit("R11 broke", broke, 1'b0);
        check_bit("R11 irq", irq, 1'b0);
        check_bit("R11 next_pc zero", next_pc == 32'h0, 1'b1);
        rst = 1'b0;

        // R2 shifts
        issue(enc_r(5'd0, 5'd2, 5'd3, 5'd4, 6'h00), 32'h100, 32'h0, 32'h8000_000F, 0, "R2 sll");
        issue(enc_r(5'd0, 5'd2, 5'd4, 5'd8, 6'h03), 32'h104, 32'h0, 32'h8000_1234, 0, "R2 sra");
        issue(enc_r(5'd0, 5'd2, 5'd5, 5'd8, 6'h02), 32'h108, 32'h0, 32'h8000_1234, 0, "R2 srl");
        issue(enc_r(5'd1, 5'd2, 5'd6, 5'd0, 6'h06), 32'h10C, 32'h0000_0025, 32'hF000_0000, 0, "R2 srlv low5");
        issue(enc_r(5'd1, 5'd2, 5'd7, 5'd0, 6'h07), 32'h110, 32'hFFFF_FFE4, 32'hF000_0000, 0, "R2 srav");
        issue(enc_r(5'd1, 5'd2, 5'd7, 5'd0, 6'h04), 32'h114, 32'h0000_003F, 32'h0000_0001, 0, "R2 sllv");
        // R3 arithmetic and logic
        issue(enc_r(5'd1, 5'd2, 5'd8, 5'd0, 6'h20), 32'h118, 32'h7FFF_FFFF, 32'h1, 0, "R3 add wrap");
        issue(enc_r(5'd1, 5'd2, 5'd8, 5'd0, 6'h22), 32'h11C, 32'h0, 32'h1, 0, "R3 sub wrap");
        issue(enc_r(5'd1, 5'd2, 5'd9, 5'd0, 6'h27), 32'h120, 32'h0F0F_0000, 32'h0000_00F0, 0, "R3 nor");
        issue(enc_r(5'd1, 5'd2, 5'd9, 5'd0, 6'h26), 32'h124, 32'hFFFF_0000, 32'h0F0F_0F0F, 0, "R3 xor");
        issue(enc_r(5'd1, 5'd2, 5'd10, 5'd0, 6'h2A), 32'h128, 32'hFFFF_FFFF, 32'h1, 0, "R3 slt signed");
        issue(enc_r(5'd1, 5'd2, 5'd10, 5'd0, 6'h2B), 32'h12C, 32'hFFFF_FFFF, 32'h1, 0, "R3 sltu");
        // R4 immediates
        issue(enc_i(6'h08, 5'd1, 5'd11, 16'hFFFE), 32'h130, 32'h5, 32'h0, 0, "R4 addi negative");
        issue(enc_i(6'h0B, 5'd1, 5'd11, 16'hFFFF), 32'h134, 32'h5, 32'h0, 0, "R4 sltiu sext");
        issue(enc_i(6'h0A, 5'd1, 5'd11, 16'hFFFF), 32'h138, 32'h5, 32'h0, 0, "R4 slti");
        issue(enc_i(6'h0C, 5'd1, 5'd12, 16'h8FF0), 32'h13C, 32'hFFFF_FFFF, 32'h0, 0, "R4 andi zext");
        issue(enc_i(6'h0D, 5'd1, 5'd12, 16'h8001), 32'h140, 32'h0, 32'h0, 0, "R4 ori zext");
        issue(enc_i(6'h0F, 5'd0, 5'd13, 16'hBEEF), 32'h144, 32'h1234_5678, 32'h0, 0, "R4 lui");
        // R5 register zero
        issue(enc_r(5'd1, 5'd2, 5'd0, 5'd0, 6'h21), 32'h148, 32'h1, 32'h2, 0, "R5 addu to r0");
        issue(enc_i(6'h0F, 5'd0, 5'd0, 16'h1111), 32'h14C, 32'h0, 32'h0, 0, "R5 lui to r0");
        // R6 conditional branches
        issue(enc_i(6'h04, 5'd1, 5'd2, 16'h0010), 32'h200, 32'h7, 32'h7, 0, "R6 beq taken");
        issue(enc_i(6'h04, 5'd1, 5'd2, 16'h0010), 32'h204, 32'h7, 32'h8, 0, "R6 beq not taken");
        issue(enc_i(6'h05, 5'd1, 5'd2, 16'hFFF0), 32'h208, 32'h7, 32'h8, 0, "R6 bne backward");
        issue(enc_i(6'h06, 5'd1, 5'd0, 16'h0004), 32'h20C, 32'h0, 32'h0, 0, "R6 blez zero");
        issue(enc_i(6'h07, 5'd1, 5'd0, 16'h0004), 32'h210, 32'h0, 32'h0, 0, "R6 bgtz zero");
        issue(enc_i(6'h01, 5'd1, 5'h00, 16'h0008), 32'h214, 32'h8000_0000, 32'h0, 0, "R6 bltz taken");
        issue(enc_i(6'h01, 5'd1, 5'h01, 16'h0008), 32'h218, 32'h8000_0000, 32'h0, 0, "R6 bgez not taken");
        // R7 linking branch
        issue(enc_i(6'h01, 5'd1, 5'h11, 16'h0020), 32'h300, 32'hFFFF_FFFF, 32'h0, 0, "R7 link not taken");
        issue(enc_i(6'h01, 5'd1, 5'h11, 16'h0020), 32'h304, 32'h0, 32'h0, 0, "R7 link taken");
        // R8 jumps
        issue({6'h02, 26'h3AB_CDEF}, 32'hF000_0400, 32'h0, 32'h0, 0, "R8 j");
        issue({6'h03, 26'h000_1000}, 32'h1FFF_FFFC, 32'h0, 32'h0, 0, "R8 jal");
        issue(enc_r(5'd3, 5'd0, 5'd0, 5'd0, 6'h08), 32'h500, 32'h0000_4444, 32'h0, 0, "R8 jr");
        issue(enc_r(5'd3, 5'd0, 5'd14, 5'd0, 6'h09), 32'h504, 32'h0000_5550, 32'h0, 0, "R8 jalr");
        // R10 illegal encodings
        issue({6'h3F, 26'h3FF_FFFF}, 32'h600, 32'h1, 32'h2, 1, "R10 bad primary");
        issue(enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'h01), 32'h604, 32'h1, 32'h2, 1, "R10 bad function");
        issue(enc_i(6'h01, 5'd1, 5'h05, 16'h0004), 32'h608, 32'h0, 32'h0, 1, "R10 bad sub-op");
        // R9 break
        issue(enc_r(5'd0, 5'd0, 5'd0, 5'd0, 6'h0D), 32'h700, 32'h0, 32'h0, 0, "R9 break no irq");
        issue(enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'h21), 32'h704, 32'h1, 32'h2, 0, "R9 sticky after break");
        issue(enc_r(5'd0, 5'd0, 5'd0, 5'd0, 6'h0D), 32'h708, 32'h0, 32'h0, 1, "R9 break with irq");
        issue(enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'h21), 32'h70C, 32'h1, 32'h2, 1, "R9 irq one cycle");

        @(negedge clk);
        issue_valid = 1'b0;
        for (int i = 0; i < 10 && exp_q.size() != 0; i++) @(negedge clk);
        check_bit("R1 queue drained", exp_q.size() == 0, 1'b1);
        @(negedge clk);
        // R1: idle cycle produces nothing; R9: flags still held
        check_bit("R1 idle res_valid", res_valid, 1'b0);
        check_bit("R1 idle wr_en", wr_en, 1'b0);
        check_bit("R1 idle irq", irq, 1'b0);
        check_bit("R9 halted held", halted, 1'b1);
        check_bit("R9 broke held", broke, 1'b1);
        finish_run();
    end

endmodule